// File: doc/BRIEF.md
# Four-Mode Serial Port with Address Filtering

This block is a byte-wide serial port of the kind found next to a small embedded processor. One 8-bit control register picks one of four line formats: a clocked shift-register format, an 8-bit asynchronous format, and two 9-bit asynchronous formats. Of the two 9-bit formats, one runs at a fixed fraction of the system clock and the other at an external rate. Software reaches four byte registers over a plain synchronous register bus. A write to the data register starts a transmission. A read of that register returns the last byte accepted by the receiver. Two level outputs mirror the transmit-done and receive-done flags, so an interrupt controller can use them.

In the asynchronous formats the receiver can filter multiprocessor traffic. When the filter is on, a frame raises the receive flag only if it carries an address marker and its byte matches this node's address under a mask, or matches the derived broadcast address. In the 9-bit formats the marker is a ninth bit of 1. In the 8-bit format it is a valid stop bit. A bad stop bit sets a sticky framing-error flag. That flag shares bit 7 of the control register with a mode bit, and an input pin picks which of the two that bit reaches.

Top module: `sio_port`

## Requirements
- R1: Bus addresses: 0 control, 1 data, 2 own address, 3 address mask. Control bits: [7] mode high (or framing error), [6] mode low, [5] filter enable, [4] receive enable, [3] transmit ninth bit, [2] received ninth bit, [1] transmit flag, [0] receive flag. Mode {[7],[6]} is 00 shift, 01 8-bit async at the rate tick, 10 9-bit async at a fixed rate, 11 9-bit async at the rate tick. All control bits and both flags are 0 after reset, and `ser_out` and `shift_clk` idle high.
- R2: When `fe_view` is 1, bit 7 of the control register reads and writes the framing-error flag and the mode-high bit keeps its value. When `fe_view` is 0, bit 7 reads and writes the mode-high bit.
- R3: In shift mode, a data write sends 8 bits LSB first on `ser_out`. Each bit lasts 12 clocks, or 6 when `fast_shift` is 1. Each bit is stable at the rising edge of `shift_clk`. The transmit flag reads 1 exactly 96 clocks after the write edge (12-clock bits) and 0 one clock earlier.
- R4: In shift mode with receive enable 1 and the receive flag 0, the port clocks in 8 bits LSB first, taking `ser_in` at each rising edge of `shift_clk`. It then sets the receive flag and puts the byte in the data register.
- R5: An async frame is a start bit of 0, the data LSB first, then control bit 3 as a ninth bit in the 9-bit modes, then a stop bit of 1. Each bit lasts 16 sample ticks. A sample tick is `rate_tick` in modes 01 and 11, and one clock in 4 (1 in 2 when `dbl_rate` is 1) in mode 10. The transmit flag is set on the tick that puts the stop bit on the line.
- R6: The async receiver confirms the start bit 8 ticks after the falling edge. It takes each following bit 16 ticks later. It sets the receive flag at the middle of the stop bit. Bit 2 gets the ninth bit in the 9-bit modes and the stop bit in the 8-bit mode.
- R7: A stop bit sampled as 0 sets the framing-error flag. Later valid frames leave it at 1, and only a control write clears it.
- R8: In the 9-bit modes with the filter on, a frame is accepted only if its ninth bit is 1 and its byte matches the own address on the mask's 1 bits, or has a 1 in every bit that is 1 in (own OR mask). A rejected frame leaves the receive flag and the data register unchanged.
- R9: In the 8-bit mode with the filter on, a frame is accepted only if its stop bit is 1 and its byte matches as in R8.
- R10: A flag that hardware sets in the same cycle as a control write that writes that flag to 0 ends up 1.
- R11: With receive enable 0, no async frame is received: the receive flag and the data register stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| fe_view | input | 1 | Routes control bit 7 to the framing-error flag |
| fast_shift | input | 1 | Shift mode uses 6-clock bits instead of 12 |
| dbl_rate | input | 1 | Mode 10 doubles its bit rate |
| rate_tick | input | 1 | 16x sample tick for modes 01 and 11 |
| ser_in | input | 1 | Serial receive line |
| ser_out | output | 1 | Serial transmit line (shift-mode data) |
| shift_clk | output | 1 | Shift-mode bit clock, idles high |
| tx_irq | output | 1 | Transmit flag |
| rx_irq | output | 1 | Receive flag |

## Verification
The transmit flag can be set by the transmitter on the same edge that software writes the control register with that flag at 0. The bench brings this about in the 8-bit mode. It drives `rate_tick` itself, counts 143 ticks after the data write, and then presents the control write together with the 144th tick. It then expects the flag at 1, with `ser_out` already showing the stop bit. One cycle earlier it confirms that the flag was still 0 and that the last data bit was on the line. A second control write with no event pending must then clear the flag.

// File: rtl/sio_pkg.sv
// Package sio_pkg
// Shared register addresses, control bit positions and the mode encoding
// for the serial port. Assumes an 8-bit control register.
package sio_pkg;
    typedef enum logic [1:0] {
        MODE_SHIFT  = 2'b00,
        MODE_ASYNC8 = 2'b01,
        MODE_FIX9   = 2'b10,
        MODE_VAR9   = 2'b11
    } sio_mode_e;

    localparam logic [1:0] ADR_CTL  = 2'd0;
    localparam logic [1:0] ADR_DATA = 2'd1;
    localparam logic [1:0] ADR_OWN  = 2'd2;
    localparam logic [1:0] ADR_MASK = 2'd3;

    localparam int B_HI   = 7;
    localparam int B_LO   = 6;
    localparam int B_FILT = 5;
    localparam int B_REN  = 4;
    localparam int B_TX9  = 3;
    localparam int B_RX9  = 2;
    localparam int B_TF   = 1;
    localparam int B_RF   = 0;
endpackage

// File: rtl/sio_tick_gen.sv
// Module sio_tick_gen
// Makes the 16x sample tick for the asynchronous formats. In the fixed-rate
// format it divides the system clock. Otherwise it passes the external
// rate tick through. Assumes FIX_DIV is a multiple of 2*OVS.
module sio_tick_gen #(
    parameter int FIX_DIV = 64,
    parameter int OVS     = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fixed_sel,
    input  logic dbl,
    input  logic ext_tick,
    output logic tick
);
    localparam int SLOW_LIM = FIX_DIV / OVS;
    localparam int FAST_LIM = SLOW_LIM / 2;
    localparam int CW       = (SLOW_LIM > 2) ? $clog2(SLOW_LIM) : 1;

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] lim;

    assign lim = dbl ? CW'(FAST_LIM - 1) : CW'(SLOW_LIM - 1);

    // Free-running divider, held at zero outside the fixed-rate format.
    always_ff @(posedge clk) begin
        if (!rst_n || !fixed_sel) cnt_q <= '0;
        else if (cnt_q >= lim)    cnt_q <= '0;
        else                      cnt_q <= cnt_q + 1'b1;
    end

    assign tick = fixed_sel ? (cnt_q >= lim) : ext_tick;
endmodule

// File: rtl/sio_async_tx.sv
// Module sio_async_tx
// Asynchronous frame transmitter: start bit, DW data bits LSB first, an
// optional ninth bit, then a stop bit, each OVS ticks long. Gives a one-cycle
// event on the tick that puts the stop bit on the line. Assumes a load
// arrives only when the line is idle.
module sio_async_tx #(
    parameter int DW  = 8,
    parameter int OVS = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          load,
    input  logic          nine,
    input  logic          ninth,
    input  logic [DW-1:0] data,
    output logic          ser_out,
    output logic          stop_evt
);
    localparam int FW = DW + 3;
    localparam int CW = $clog2(OVS);
    localparam int BW = $clog2(FW + 1);

    logic [FW-1:0] sh_q;
    logic [CW-1:0] cnt_q;
    logic [BW-1:0] left_q;
    logic          last_tick;

    assign last_tick = tick && (left_q != '0) && (cnt_q == CW'(OVS - 1));

    // Frame shifter and bit-time counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q   <= '1;
            cnt_q  <= '0;
            left_q <= '0;
        end else if (load) begin
            sh_q   <= nine ? {1'b1, ninth, data, 1'b0} : {2'b11, data, 1'b0};
            left_q <= nine ? BW'(FW) : BW'(FW - 1);
            cnt_q  <= '0;
        end else if (tick && left_q != '0) begin
            if (last_tick) begin
                cnt_q  <= '0;
                sh_q   <= {1'b1, sh_q[FW-1:1]};
                left_q <= left_q - 1'b1;
            end else begin
                cnt_q  <= cnt_q + 1'b1;
            end
        end
    end

    assign ser_out  = sh_q[0];
    assign stop_evt = last_tick && (left_q == BW'(2));

    // R5: the transmit event coincides with the stop bit appearing.
    a_r5_stop_follows_event: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> ser_out);
endmodule

// File: rtl/sio_async_rx.sv
// Module sio_async_rx
// Asynchronous frame receiver with OVS-times oversampling. It confirms the
// start bit at mid-bit, then samples each bit at mid-bit. It gives a
// one-cycle done at the middle of the stop bit. Assumes ser_in is already
// synchronous to clk.
module sio_async_rx #(
    parameter int DW  = 8,
    parameter int OVS = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          en,
    input  logic          nine,
    input  logic          ser_in,
    output logic          done,
    output logic [DW-1:0] byte_o,
    output logic          ninth_o,
    output logic          stop_o
);
    localparam int CW = $clog2(OVS);
    localparam int BW = $clog2(DW + 1);

    typedef enum logic [1:0] {S_IDLE, S_START, S_DATA, S_STOP} rx_st_e;

    rx_st_e        st_q;
    logic [CW-1:0] cnt_q;
    logic [BW-1:0] bit_q;
    logic [DW:0]   sh_q;
    logic [BW-1:0] last_bit;

    assign last_bit = nine ? BW'(DW) : BW'(DW - 1);

    // Frame sequencer: hunt, confirm start, sample data, sample stop.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            st_q  <= S_IDLE;
            cnt_q <= '0;
            bit_q <= '0;
            if (!rst_n) sh_q <= '0;
        end else if (tick) begin
            case (st_q)
                S_IDLE: if (!ser_in) begin
                    st_q  <= S_START;
                    cnt_q <= '0;
                end
                S_START: if (cnt_q == CW'(OVS / 2 - 1)) begin
                    st_q  <= ser_in ? S_IDLE : S_DATA;
                    cnt_q <= '0;
                    bit_q <= '0;
                end else cnt_q <= cnt_q + 1'b1;
                S_DATA: if (cnt_q == CW'(OVS - 1)) begin
                    cnt_q <= '0;
                    sh_q  <= {ser_in, sh_q[DW:1]};
                    if (bit_q == last_bit) st_q <= S_STOP;
                    else                   bit_q <= bit_q + 1'b1;
                end else cnt_q <= cnt_q + 1'b1;
                default: if (cnt_q == CW'(OVS - 1)) begin
                    st_q  <= S_IDLE;
                    cnt_q <= '0;
                end else cnt_q <= cnt_q + 1'b1;
            endcase
        end
    end

    assign done    = tick && (st_q == S_STOP) && (cnt_q == CW'(OVS - 1));
    assign byte_o  = nine ? sh_q[DW-1:0] : sh_q[DW:1];
    assign ninth_o = sh_q[DW];
    assign stop_o  = ser_in;
endmodule

// File: rtl/sio_sync_eng.sv
// Module sio_sync_eng
// Shift-register format engine. It sends or receives DW bits LSB first with
// a bit clock that idles high. Data changes on the falling edge and is
// sampled on the rising edge. Assumes SLOW_DIV and FAST_DIV are even.
module sio_sync_eng #(
    parameter int DW       = 8,
    parameter int SLOW_DIV = 12,
    parameter int FAST_DIV = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fast,
    input  logic          start_tx,
    input  logic          start_rx,
    input  logic [DW-1:0] tx_data,
    input  logic          ser_in,
    output logic          busy,
    output logic          ser_out,
    output logic          sclk,
    output logic          done_tx,
    output logic          done_rx,
    output logic [DW-1:0] rx_byte
);
    localparam int PW = $clog2(SLOW_DIV);
    localparam int BW = (DW > 2) ? $clog2(DW) : 1;

    logic          act_q, is_tx_q, sclk_q;
    logic [PW-1:0] ph_q, last_ph, mid_ph;
    logic [BW-1:0] bit_q;
    logic [DW-1:0] sh_q;
    logic          end_bit;

    assign last_ph = fast ? PW'(FAST_DIV - 1) : PW'(SLOW_DIV - 1);
    assign mid_ph  = fast ? PW'(FAST_DIV / 2 - 1) : PW'(SLOW_DIV / 2 - 1);
    assign end_bit = act_q && (ph_q == last_ph);

    // Bit-phase sequencer, bit clock and the shared shift register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= 1'b0; is_tx_q <= 1'b0; sclk_q <= 1'b1;
            ph_q  <= '0;   bit_q   <= '0;   sh_q   <= '0;
        end else if (!act_q) begin
            if (start_tx || start_rx) begin
                act_q   <= 1'b1;
                is_tx_q <= start_tx;
                sclk_q  <= 1'b0;
                ph_q    <= '0;
                bit_q   <= '0;
                if (start_tx) sh_q <= tx_data;
            end
        end else if (ph_q == mid_ph) begin
            sclk_q <= 1'b1;
            ph_q   <= ph_q + 1'b1;
            if (!is_tx_q) sh_q <= {ser_in, sh_q[DW-1:1]};
        end else if (end_bit) begin
            ph_q  <= '0;
            bit_q <= bit_q + 1'b1;
            if (is_tx_q) sh_q <= {1'b1, sh_q[DW-1:1]};
            if (bit_q == BW'(DW - 1)) act_q <= 1'b0;
            else                      sclk_q <= 1'b0;
        end else begin
            ph_q <= ph_q + 1'b1;
        end
    end

    assign busy    = act_q;
    assign sclk    = sclk_q;
    assign ser_out = (act_q && is_tx_q) ? sh_q[0] : 1'b1;
    assign done_tx = end_bit && is_tx_q && (bit_q == BW'(DW - 1));
    assign done_rx = end_bit && !is_tx_q && (bit_q == BW'(DW - 1));
    assign rx_byte = sh_q;

    // R3: a finished transfer leaves the engine idle with the clock high.
    a_r3_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        (done_tx || done_rx) |=> (!busy && sclk));
endmodule

// File: rtl/sio_port.sv
// Module sio_port
// Four-mode serial port: control register, own-address and mask registers,
// receive buffer, multiprocessor address filter and framing-error flag.
// Assumes a synchronous register bus with a combinational read and
// serial inputs already synchronous to clk.
module sio_port #(
    parameter int DW       = 8,
    parameter int SLOW_DIV = 12,
    parameter int FAST_DIV = 6,
    parameter int FIX_DIV  = 64,
    parameter int OVS      = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic [1:0]    bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          fe_view,
    input  logic          fast_shift,
    input  logic          dbl_rate,
    input  logic          rate_tick,
    input  logic          ser_in,
    output logic          ser_out,
    output logic          shift_clk,
    output logic          tx_irq,
    output logic          rx_irq
);
    import sio_pkg::*;

    logic          hi_q, lo_q, filt_q, ren_q, tx9_q, rx9_q, tf_q, rf_q, fe_q;
    logic [DW-1:0] own_q, mask_q, rbuf_q, bcast;
    sio_mode_e     mode;
    logic          is_async, nine, wr_ctl, wr_data, tick;
    logic          s_busy, s_out, s_done_tx, s_done_rx;
    logic [DW-1:0] s_byte, a_byte;
    logic          a_out, a_stop_evt, a_done, a_ninth, a_stop;
    logic          hit, accept, tf_evt, rf_evt, fe_evt;

    assign mode     = sio_mode_e'({hi_q, lo_q});
    assign is_async = (mode != MODE_SHIFT);
    assign nine     = hi_q;
    assign wr_ctl   = bus_wr && (bus_addr == ADR_CTL);
    assign wr_data  = bus_wr && (bus_addr == ADR_DATA);

    sio_tick_gen #(.FIX_DIV(FIX_DIV), .OVS(OVS)) u_tick (
        .clk(clk), .rst_n(rst_n), .fixed_sel(mode == MODE_FIX9),
        .dbl(dbl_rate), .ext_tick(rate_tick), .tick(tick));

    sio_sync_eng #(.DW(DW), .SLOW_DIV(SLOW_DIV), .FAST_DIV(FAST_DIV)) u_sync (
        .clk(clk), .rst_n(rst_n), .fast(fast_shift),
        .start_tx(wr_data && !is_async),
        .start_rx(!is_async && ren_q && !rf_q && !s_busy && !wr_data),
        .tx_data(bus_wdata), .ser_in(ser_in), .busy(s_busy), .ser_out(s_out),
        .sclk(shift_clk), .done_tx(s_done_tx), .done_rx(s_done_rx), .rx_byte(s_byte));

    sio_async_tx #(.DW(DW), .OVS(OVS)) u_atx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .load(wr_data && is_async),
        .nine(nine), .ninth(tx9_q), .data(bus_wdata), .ser_out(a_out),
        .stop_evt(a_stop_evt));

    sio_async_rx #(.DW(DW), .OVS(OVS)) u_arx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .en(ren_q && is_async),
        .nine(nine), .ser_in(ser_in), .done(a_done), .byte_o(a_byte),
        .ninth_o(a_ninth), .stop_o(a_stop));

    // Address filter: masked own-address match or broadcast match.
    assign bcast  = own_q | mask_q;
    assign hit    = (((a_byte ^ own_q) & mask_q) == '0) || ((a_byte & bcast) == bcast);
    assign accept = !filt_q || ((nine ? a_ninth : a_stop) && hit);

    assign tf_evt = s_done_tx || a_stop_evt;
    assign rf_evt = s_done_rx || (a_done && accept);
    assign fe_evt = a_done && !a_stop;

    // Control register: software write first, hardware events take priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {hi_q, lo_q, filt_q, ren_q, tx9_q, rx9_q, tf_q, rf_q, fe_q} <= '0;
        end else begin
            if (wr_ctl) begin
                if (fe_view) fe_q <= bus_wdata[B_HI];
                else         hi_q <= bus_wdata[B_HI];
                lo_q   <= bus_wdata[B_LO];
                filt_q <= bus_wdata[B_FILT];
                ren_q  <= bus_wdata[B_REN];
                tx9_q  <= bus_wdata[B_TX9];
                rx9_q  <= bus_wdata[B_RX9];
                tf_q   <= bus_wdata[B_TF];
                rf_q   <= bus_wdata[B_RF];
            end
            if (tf_evt) tf_q <= 1'b1;
            if (rf_evt) rf_q <= 1'b1;
            if (fe_evt) fe_q <= 1'b1;
            if (a_done && accept) rx9_q <= nine ? a_ninth : a_stop;
        end
    end

    // Address registers and receive buffer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            own_q <= '0; mask_q <= '0; rbuf_q <= '0;
        end else begin
            if (bus_wr && bus_addr == ADR_OWN)  own_q  <= bus_wdata;
            if (bus_wr && bus_addr == ADR_MASK) mask_q <= bus_wdata;
            if (s_done_rx)                      rbuf_q <= s_byte;
            else if (a_done && accept)          rbuf_q <= a_byte;
        end
    end

    // Read multiplexer with the bit-7 alias.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADR_CTL:  bus_rdata[7:0] = {fe_view ? fe_q : hi_q, lo_q, filt_q, ren_q,
                                        tx9_q, rx9_q, tf_q, rf_q};
            ADR_DATA: bus_rdata = rbuf_q;
            ADR_OWN:  bus_rdata = own_q;
            default:  bus_rdata = mask_q;
        endcase
    end

    assign ser_out = is_async ? a_out : s_out;
    assign tx_irq  = tf_q;
    assign rx_irq  = rf_q;

    // R10: a transmit event always leaves the flag set.
    a_r10_tf_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        tf_evt |=> tx_irq);
    // R6: a receive event always leaves the flag set.
    a_r6_rf_follows_event: assert property (@(posedge clk) disable iff (!rst_n)
        rf_evt |=> rx_irq);
    // R7: the framing-error flag only falls through a control write.
    a_r7_fe_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (fe_q && !(wr_ctl && fe_view)) |=> fe_q);
    // R8: a 9-bit frame without the address marker cannot raise the flag.
    a_r8_marker_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (a_done && filt_q && nine && !a_ninth && !wr_ctl) |=> (rx_irq == $past(rx_irq)));
    // R11: the receive flag rises only with reception enabled or by software.
    a_r11_rx_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rx_irq) && !$past(wr_ctl)) |-> $past(ren_q));
endmodule

// File: tb/test_sio_port.sv
module test_sio_port;
    import sio_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       fe_view = 1'b0, fast_shift = 1'b0, dbl_rate = 1'b0, rate_tick = 1'b1;
    logic       drv_in = 1'b1, loop_en = 1'b0;
    logic       ser_out, shift_clk, tx_irq, rx_irq, line_in;
    int         n_chk = 0, n_fail = 0;

    assign line_in = loop_en ? ser_out : drv_in;

    always #5 clk = ~clk;

    sio_port i_sio_port (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .fe_view(fe_view),
        .fast_shift(fast_shift), .dbl_rate(dbl_rate), .rate_tick(rate_tick),
        .ser_in(line_in), .ser_out(ser_out), .shift_clk(shift_clk),
        .tx_irq(tx_irq), .rx_irq(rx_irq));

    // Shift-mode capture and drive, clocked by the port's bit clock.
    logic       cap_en = 1'b0, rx0_en = 1'b0;
    logic [7:0] cap_byte = 8'h00, rx0_pat = 8'h00;
    int         rx0_n = 0;
    always @(posedge shift_clk) begin
        if (cap_en) cap_byte = {ser_out, cap_byte[7:1]};
        if (rx0_en) begin
            rx0_n++;
            if (rx0_n < 8) drv_in = rx0_pat[rx0_n];
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic send_bits(input logic [9:0] bits, input int n);
        for (int b = 0; b < n; b++) begin
            drv_in = bits[b];
            repeat (16) @(negedge clk);
        end
        drv_in = 1'b1;
        repeat (20) @(negedge clk);
    endtask

    typedef struct packed {
        logic [7:0] ctl;
        logic [7:0] data;
        logic [7:0] own;
        logic [7:0] mask;
        logic       dbl;
        logic       exp_rf;
        logic       exp_rx9;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{8'h50, 8'h3C, 8'h00, 8'h00, 1'b0, 1'b1, 1'b1}, // R6 8-bit, stop in bit 2
        '{8'hD8, 8'h81, 8'h00, 8'h00, 1'b0, 1'b1, 1'b1}, // R5 ninth bit 1
        '{8'hD0, 8'h7E, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0}, // R5 ninth bit 0
        '{8'hF8, 8'h12, 8'h12, 8'hFF, 1'b0, 1'b1, 1'b1}, // R8 own match
        '{8'hF0, 8'h12, 8'h12, 8'hFF, 1'b0, 1'b0, 1'b0}, // R8 no marker
        '{8'hF8, 8'h13, 8'h12, 8'hFF, 1'b0, 1'b0, 1'b0}, // R8 mismatch
        '{8'hF8, 8'hFF, 8'h12, 8'hFF, 1'b0, 1'b1, 1'b1}, // R8 broadcast
        '{8'hF8, 8'h1A, 8'h12, 8'hF0, 1'b0, 1'b1, 1'b1}, // R8 masked match
        '{8'hF8, 8'h2A, 8'h12, 8'hF0, 1'b0, 1'b0, 1'b0}, // R8 masked miss
        '{8'hB8, 8'h40, 8'h40, 8'hFF, 1'b0, 1'b1, 1'b1}, // R5 fixed rate
        '{8'h98, 8'hC3, 8'h00, 8'h00, 1'b1, 1'b1, 1'b1}, // R5 fixed doubled
        '{8'h70, 8'h55, 8'h55, 8'hFF, 1'b0, 1'b1, 1'b1}, // R9 match
        '{8'h70, 8'h56, 8'h55, 8'hFF, 1'b0, 1'b0, 1'b0}, // R9 miss
        '{8'h40, 8'h77, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0}  // R11 receive off
    };

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] rd, last_rx;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        bus_read(ADR_CTL, rd);   chk("R1 ctl reset", rd, 8'h00);
        fe_view = 1'b1;
        bus_read(ADR_CTL, rd);   chk("R1 fe reset", rd, 8'h00);
        fe_view = 1'b0;
        chk("R1 lines idle", {ser_out, shift_clk, tx_irq, rx_irq}, 4'b1100);

        // R3 shift-mode transmit and flag timing
        cap_en = 1'b1;
        bus_write(ADR_DATA, 8'hA5);
        repeat (95) @(negedge clk);
        chk("R3 tf before end", tx_irq, 1'b0);
        @(negedge clk);
        chk("R3 tf at end", tx_irq, 1'b1);
        cap_en = 1'b0;
        chk("R3 shifted bits", cap_byte, 8'hA5);
        chk("R3 line idle", {ser_out, shift_clk}, 2'b11);

        // R4 shift-mode receive, fast bit time
        bus_write(ADR_CTL, 8'h00);
        fast_shift = 1'b1; rx0_pat = 8'h6B; rx0_n = 0; drv_in = rx0_pat[0];
        rx0_en = 1'b1;
        bus_write(ADR_CTL, 8'h10);
        repeat (70) @(negedge clk);
        rx0_en = 1'b0; drv_in = 1'b1;
        chk("R4 rf set", {tx_irq, rx_irq}, 2'b01);
        bus_read(ADR_DATA, rd);  chk("R4 rx byte", rd, 8'h6B);
        last_rx = rd;
        bus_write(ADR_CTL, 8'h00);
        fast_shift = 1'b0;

        // Vector table over the asynchronous formats, looped back
        for (int k = 0; k < NV; k++) begin
            bus_write(ADR_OWN, VECS[k].own);
            bus_write(ADR_MASK, VECS[k].mask);
            bus_write(ADR_CTL, VECS[k].ctl);
            dbl_rate = VECS[k].dbl; loop_en = 1'b1; rate_tick = 1'b1;
            bus_write(ADR_DATA, VECS[k].data);
            repeat (800) @(negedge clk);
            bus_read(ADR_CTL, rd);
            chk($sformatf("R5 tf vec %0d", k), rd[B_TF], 1'b1);
            chk($sformatf("R8 R9 R11 rf vec %0d", k), rd[B_RF], VECS[k].exp_rf);
            if (VECS[k].exp_rf) begin
                chk($sformatf("R6 rx9 vec %0d", k), rd[B_RX9], VECS[k].exp_rx9);
                last_rx = VECS[k].data;
            end
            bus_read(ADR_DATA, rd);
            chk($sformatf("R6 R8 data vec %0d", k), rd, last_rx);
            bus_write(ADR_CTL, 8'h00);
        end
        loop_en = 1'b0; dbl_rate = 1'b0;

        // R7 framing error, sticky; R2 bit-7 alias
        fe_view = 1'b1;
        bus_write(ADR_CTL, 8'h50);
        send_bits({1'b0, 8'hC9, 1'b0}, 10);
        bus_read(ADR_CTL, rd);
        chk("R7 fe set", rd[B_HI], 1'b1);
        chk("R6 rf with bad stop", {rd[B_RX9], rd[B_RF]}, 2'b01);
        bus_write(ADR_CTL, 8'hD0);
        send_bits({1'b1, 8'h5A, 1'b0}, 10);
        bus_read(ADR_CTL, rd);
        chk("R7 fe stays", {rd[B_HI], rd[B_RF]}, 2'b11);
        bus_read(ADR_DATA, rd);  chk("R7 valid byte", rd, 8'h5A);
        bus_write(ADR_CTL, 8'h50);
        bus_read(ADR_CTL, rd);   chk("R7 fe cleared", rd[B_HI], 1'b0);
        fe_view = 1'b0;
        bus_read(ADR_CTL, rd);   chk("R2 mode bit view", rd[B_HI], 1'b0);
        bus_write(ADR_CTL, 8'hC0);
        bus_read(ADR_CTL, rd);   chk("R2 mode bit written", rd[B_HI], 1'b1);
        fe_view = 1'b1;
        bus_read(ADR_CTL, rd);   chk("R2 fe view", rd[B_HI], 1'b0);
        fe_view = 1'b0;

        // R10 transmit event and clearing write on the same edge
        bus_write(ADR_CTL, 8'h40);
        rate_tick = 1'b0;
        bus_write(ADR_DATA, 8'h00);
        rate_tick = 1'b1;
        repeat (143) @(negedge clk);
        chk("R10 tf before", tx_irq, 1'b0);
        chk("R5 last data bit", ser_out, 1'b0);
        bus_wr = 1'b1; bus_addr = ADR_CTL; bus_wdata = 8'h40;
        @(negedge clk);
        bus_wr = 1'b0;
        chk("R10 tf wins", tx_irq, 1'b1);
        chk("R5 stop on line", ser_out, 1'b1);
        repeat (20) @(negedge clk);
        bus_write(ADR_CTL, 8'h40);
        chk("R10 plain clear", tx_irq, 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule